// File: doc/BRIEF.md
# Alarm Timer with Prescaler and Snapshot Readout

This block is a 54-bit general-purpose timer. It counts up or down on a tick from a 16-bit programmable prescaler. It compares the count against an alarm value and raises a level interrupt when the two match. Software drives it through a plain register port. Every write takes effect on one clock edge, and read data is registered, so it appears one cycle after the address.

The running count is never read directly. Software asks for a copy through a self-clearing request bit and then reads two snapshot words. The count can be forced to a preset value by writing the preset words and then pulsing a separate load register. The alarm-arm bit disarms itself each time the alarm fires. If auto-reload is set, the preset value is also loaded into the count on the same tick as the match.

Register word addresses:

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Snapshot request |
| 2, 3 | Snapshot low and high |
| 4, 5 | Preset low and high |
| 6 | Load pulse |
| 7, 8 | Alarm low and high |
| 9 | Interrupt raw |
| 10 | Interrupt enable |
| 11 | Interrupt clear |

Control bit fields: bit 0 is run, bit 1 is direction (1 counts up), bit 2 is auto-reload, bit 3 is arm, and bits 31:16 are the prescaler setting.

Top module: `gp_alarm_timer`

## Requirements
- R1: After reset, control reads 0x00020002 (stopped, counting up, prescaler setting 2). Snapshot words, interrupt raw and irq_o all read 0.
- R2: Prescaler setting 0 divides the clock by 65536. Settings 1 and 2 both divide by 2. Any other setting N divides by N. Counting starts from a cleared prescaler each time run goes from 0 to 1.
- R3: While run (bit 0) is 1, the count changes by one on each prescaler tick: up when bit 1 is 1, down when it is 0. It wraps modulo 2^54 in both directions and holds while run is 0.
- R4: Writing 1 to bit 0 of address 1 requests a snapshot. That bit reads 1 in the first read after the request and 0 after that. One cycle after the request, addresses 2 and 3 hold the count.
- R5: A write of any value to address 6 loads the count from the preset words at addresses 4 and 5.
- R6: When arm (bit 3) is 1 and the count equals the alarm value on a tick, interrupt raw (address 9, bit 0) is set and arm reads back 0.
- R7: When auto-reload (bit 2) is also 1, the match tick loads the preset value into the count instead of stepping it.
- R8: irq_o equals raw AND enable (address 10, bit 0). Writing 1 to bit 0 of address 11 clears raw, and writing 0 there has no effect.
- R9: The high words at addresses 3, 5 and 8 carry 22 bits. Bits above them read as 0 and do not affect the stored value.
- R10: While stopped, writes to the control, alarm and preset registers leave the count unchanged.
- R11: With arm at 0, a count passing through the alarm value does not set raw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong prescaler phase or divisor shows up as a count in the snapshot that is off by one or more ticks. This becomes visible one cycle after the next snapshot request. A stuck or misplaced match shows at irq_o and in the control readback, because arm stays at 1 or raw stays at 0 after the alarm tick. With auto-reload set, a mishandled match leaves a count far from the preset-based value. Wrap errors at the 54-bit boundary appear as a bad high snapshot word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] A_CTRL   = 4'd0;
  localparam logic [REG_AW-1:0] A_SREQ   = 4'd1;
  localparam logic [REG_AW-1:0] A_SLO    = 4'd2;
  localparam logic [REG_AW-1:0] A_SHI    = 4'd3;
  localparam logic [REG_AW-1:0] A_PLO    = 4'd4;
  localparam logic [REG_AW-1:0] A_PHI    = 4'd5;
  localparam logic [REG_AW-1:0] A_LOAD   = 4'd6;
  localparam logic [REG_AW-1:0] A_ALO    = 4'd7;
  localparam logic [REG_AW-1:0] A_AHI    = 4'd8;
  localparam logic [REG_AW-1:0] A_IRAW   = 4'd9;
  localparam logic [REG_AW-1:0] A_IENA   = 4'd10;
  localparam logic [REG_AW-1:0] A_ICLR   = 4'd11;
  localparam int B_RUN = 0;
  localparam int B_UP  = 1;
  localparam int B_ARL = 2;
  localparam int B_ARM = 3;
  localparam int PS_LSB = 16;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] div_sel,
  output logic            tick
);
  localparam int CW = PS_W + 1;

  logic [CW-1:0] lim;
  logic [CW-1:0] pcnt;

  always_comb begin
    if (div_sel == '0)
      lim = {1'b0, {PS_W{1'b1}}};
    else if (div_sel <= PS_W'(2))
      lim = CW'(1);
    else
      lim = {1'b0, div_sel} - CW'(1);
  end

  assign tick = run && (pcnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run)
      pcnt <= '0;
    else if (pcnt >= lim)
      pcnt <= '0;
    else
      pcnt <= pcnt + CW'(1);
  end

  // R2
  ps_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pcnt == '0));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 54
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             up,
  input  logic             arl,
  input  logic             arm,
  input  logic             load,
  input  logic [CNT_W-1:0] preset,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);
  assign fire = tick && arm && (cnt == alarm);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= preset;
    else if (tick) begin
      if (fire && arl)
        cnt <= preset;
      else if (up)
        cnt <= cnt + CNT_W'(1);
      else
        cnt <= cnt - CNT_W'(1);
    end
  end

  // R3
  hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt));
  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && !fire && up) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && arl && !load) |=> (cnt == $past(preset)));
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
  parameter int CNT_W = 54
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic [CNT_W-1:0] snap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      snap <= '0;
    end else begin
      if (busy) begin
        snap <= cnt;
        busy <= 1'b0;
      end else if (req) begin
        busy <= 1'b1;
      end
    end
  end

  // R4
  busy_once_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic ena_we,
  input  logic ena_d,
  output logic raw,
  output logic ena,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= 1'b0;
      ena <= 1'b0;
    end else begin
      if (set)
        raw <= 1'b1;
      else if (clr)
        raw <= 1'b0;
      if (ena_we)
        ena <= ena_d;
    end
  end

  assign irq = raw & ena;

  // R6
  set_raw_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> raw);
  // R8
  clr_raw_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !raw);
endmodule

// File: rtl/gp_alarm_timer.sv
module gp_alarm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 54,
  parameter int DATA_W = 32,
  parameter int PS_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;
  localparam int GAP_W = PS_LSB - 4;

  logic            run_q, up_q, arl_q, arm_q;
  logic [PS_W-1:0] ps_q;
  logic [CNT_W-1:0] preset_q, alarm_q;

  logic wr_ctrl, wr_sreq, wr_load, wr_iena, wr_iclr;
  logic tick, fire, busy, raw, ena;
  logic [CNT_W-1:0] cnt, snap;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_sreq = reg_we && (reg_addr == A_SREQ) && reg_wdata[0];
  assign wr_load = reg_we && (reg_addr == A_LOAD);
  assign wr_iena = reg_we && (reg_addr == A_IENA);
  assign wr_iclr = reg_we && (reg_addr == A_ICLR) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      up_q     <= 1'b1;
      arl_q    <= 1'b0;
      arm_q    <= 1'b0;
      ps_q     <= PS_W'(2);
      preset_q <= '0;
      alarm_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= reg_wdata[B_RUN];
        up_q  <= reg_wdata[B_UP];
        arl_q <= reg_wdata[B_ARL];
        arm_q <= reg_wdata[B_ARM];
        ps_q  <= reg_wdata[PS_LSB +: PS_W];
      end else if (fire) begin
        arm_q <= 1'b0;
      end
      if (reg_we && reg_addr == A_PLO) preset_q[DATA_W-1:0]     <= reg_wdata;
      if (reg_we && reg_addr == A_PHI) preset_q[CNT_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
      if (reg_we && reg_addr == A_ALO) alarm_q[DATA_W-1:0]      <= reg_wdata;
      if (reg_we && reg_addr == A_AHI) alarm_q[CNT_W-1:DATA_W]  <= reg_wdata[HI_W-1:0];
    end
  end

  tmr_prescale #(.PS_W(PS_W)) i_pre (
    .clk(clk), .rst(rst), .run(run_q), .div_sel(ps_q), .tick(tick)
  );

  tmr_core #(.CNT_W(CNT_W)) i_core (
    .clk(clk), .rst(rst), .tick(tick), .up(up_q), .arl(arl_q), .arm(arm_q),
    .load(wr_load), .preset(preset_q), .alarm(alarm_q), .cnt(cnt), .fire(fire)
  );

  tmr_snap #(.CNT_W(CNT_W)) i_snap (
    .clk(clk), .rst(rst), .req(wr_sreq), .cnt(cnt), .busy(busy), .snap(snap)
  );

  tmr_irq i_irq (
    .clk(clk), .rst(rst), .set(fire), .clr(wr_iclr), .ena_we(wr_iena),
    .ena_d(reg_wdata[0]), .raw(raw), .ena(ena), .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_CTRL: reg_rdata <= {ps_q, {GAP_W{1'b0}}, arm_q, arl_q, up_q, run_q};
        A_SREQ: reg_rdata <= {{(DATA_W-1){1'b0}}, busy};
        A_SLO:  reg_rdata <= snap[DATA_W-1:0];
        A_SHI:  reg_rdata <= {{PAD_W{1'b0}}, snap[CNT_W-1:DATA_W]};
        A_PLO:  reg_rdata <= preset_q[DATA_W-1:0];
        A_PHI:  reg_rdata <= {{PAD_W{1'b0}}, preset_q[CNT_W-1:DATA_W]};
        A_ALO:  reg_rdata <= alarm_q[DATA_W-1:0];
        A_AHI:  reg_rdata <= {{PAD_W{1'b0}}, alarm_q[CNT_W-1:DATA_W]};
        A_IRAW: reg_rdata <= {{(DATA_W-1){1'b0}}, raw};
        A_IENA: reg_rdata <= {{(DATA_W-1){1'b0}}, ena};
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R6
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !wr_ctrl) |=> !arm_q);
  // R11
  no_arm_chk: assert property (@(posedge clk) disable iff (rst)
    !arm_q |-> !fire);
endmodule

// File: tb/test_gp_alarm_timer.sv
module test_gp_alarm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 54;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_alarm_timer i_gp_alarm_timer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic int divisor(input int ps);
    if (ps == 0) return 65536;
    if (ps <= 2) return 2;
    return ps;
  endfunction

  function automatic logic [CW-1:0] expect_cnt(input logic [CW-1:0] s, input bit up,
                                               input int ticks);
    if (up) return s + CW'(ticks);
    return s - CW'(ticks);
  endfunction

  function automatic logic [31:0] ctrl_word(input bit run, input bit up, input bit arl,
                                            input bit arm, input int ps);
    return {ps[15:0], 12'b0, arm, arl, up, run};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic snapshot(output logic [CW-1:0] v);
    logic [31:0] lo, hi;
    wr(4'd1, 32'd1);
    idle(1);
    rd(4'd2, lo);
    rd(4'd3, hi);
    v = {hi[21:0], lo};
  endtask

  task automatic preload(input logic [CW-1:0] v);
    wr(4'd4, v[31:0]);
    wr(4'd5, {10'b0, v[53:32]});
    wr(4'd6, 32'h0);
  endtask

  task automatic run_case(input string tag, input logic [CW-1:0] s, input bit up,
                          input int ps, input int m);
    logic [CW-1:0] v;
    preload(s);
    wr(4'd0, ctrl_word(1, up, 0, 0, ps));
    idle(m);
    wr(4'd0, ctrl_word(0, up, 0, 0, ps));
    snapshot(v);
    chk(tag, 64'(v), 64'(expect_cnt(s, up, (m + 1) / divisor(ps))));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [CW-1:0] v, s;
    void'($urandom(1234));
    idle(3);
    rst = 1'b0;

    // R1 reset state
    rd(4'd0, d); chk("R1 ctrl", 64'(d), 64'h00020002);
    rd(4'd9, d); chk("R1 raw", 64'(d), 64'h0);
    chk("R1 irq", 64'(irq_o), 64'h0);
    snapshot(v); chk("R1 snap", 64'(v), 64'h0);

    // R4 busy bit readback
    wr(4'd1, 32'd1);
    rd(4'd1, d); chk("R4 busy set", 64'(d), 64'h1);
    rd(4'd1, d); chk("R4 busy cleared", 64'(d), 64'h0);

    // R5 load and R9 high word masking
    s = 54'h2A_BCDE_0123_4567;
    wr(4'd4, s[31:0]);
    wr(4'd5, {10'h3FF, s[53:32]});
    rd(4'd5, d); chk("R9 preset hi", 64'(d), 64'(s[53:32]));
    wr(4'd6, 32'hDEAD_BEEF);
    snapshot(v); chk("R5 load", 64'(v), 64'(s));
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, d); chk("R9 alarm hi", 64'(d), 64'h003F_FFFF);

    // R10 writes while stopped
    wr(4'd0, ctrl_word(0, 0, 1, 0, 7));
    wr(4'd7, 32'h1234);
    wr(4'd4, 32'h5555);
    snapshot(v); chk("R10 stopped count", 64'(v), 64'(s));

    // R2 R3 directed: divider encodings and wrap
    run_case("R2 ps1", 54'd100, 1, 1, 9);
    run_case("R2 ps2", 54'd100, 1, 2, 9);
    run_case("R3 wrap down", 54'd0, 0, 3, 5);
    run_case("R3 wrap up", {CW{1'b1}}, 1, 3, 2);
    run_case("R2 ps0", 54'd7, 1, 0, 65535);
    run_case("R2 ps0 short", 54'd7, 1, 0, 100);

    // R2 R3 random
    for (int i = 0; i < 12; i++) begin
      logic [CW-1:0] rs;
      rs = {22'($urandom), 32'($urandom)};
      run_case("R3 random", rs, 1'($urandom), 1 + int'($urandom % 12), int'($urandom % 60));
    end

    // R6 R8 alarm without auto-reload, enable off first
    s = 54'h00_0000_0001_0000;
    preload(s);
    wr(4'd7, s[31:0] + 32'd3);
    wr(4'd8, 32'h0);
    wr(4'd0, ctrl_word(1, 1, 0, 1, 2));
    idle(14);
    rd(4'd0, d); chk("R6 arm cleared", 64'(d[3]), 64'h0);
    wr(4'd0, ctrl_word(0, 1, 0, 0, 2));
    snapshot(v); chk("R6 count after fire", 64'(v), 64'(s + 54'd8));
    rd(4'd9, d); chk("R6 raw set", 64'(d), 64'h1);
    chk("R8 irq masked", 64'(irq_o), 64'h0);
    wr(4'd10, 32'd1);
    chk("R8 irq on", 64'(irq_o), 64'h1);
    wr(4'd11, 32'd0);
    rd(4'd9, d); chk("R8 clear zero ignored", 64'(d), 64'h1);
    wr(4'd11, 32'd1);
    rd(4'd9, d); chk("R8 raw cleared", 64'(d), 64'h0);
    chk("R8 irq off", 64'(irq_o), 64'h0);

    // R7 auto-reload on match
    preload(s);
    wr(4'd4, 32'h0000_9000);
    wr(4'd5, 32'h0);
    wr(4'd0, ctrl_word(1, 1, 1, 1, 2));
    idle(14);
    rd(4'd9, d); chk("R7 raw", 64'(d), 64'h1);
    wr(4'd0, ctrl_word(0, 1, 1, 0, 2));
    snapshot(v); chk("R7 reload count", 64'(v), 64'h9004);
    chk("R7 irq", 64'(irq_o), 64'h1);
    wr(4'd11, 32'd1);

    // R11 no fire when not armed
    preload(s);
    wr(4'd0, ctrl_word(1, 1, 0, 0, 2));
    idle(15);
    wr(4'd0, ctrl_word(0, 1, 0, 0, 2));
    rd(4'd9, d); chk("R11 raw stays", 64'(d), 64'h0);
    snapshot(v); chk("R11 count passes", 64'(v), 64'(s + 54'd8));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule